// File: doc/BRIEF.md
# Branch Decision Unit

This block sits in the execute stage of a 32-bit RISC core and resolves every branch instruction it is handed. Given the instruction word, the address of that instruction, the two source register values and an already sign-extended immediate, it decides whether the branch is taken. It also forms the target address, asks for the instruction address to be written to a link register, flags whether a delay slot follows, and pulses a strobe that sets the break-in-progress status bit.

Two families are recognised. Unconditional branches carry three independent modifier bits: delay slot, absolute target and link. Conditional branches test one register, Ra, against zero with a signed comparison, and may request a delay slot. Each family comes in two forms: one takes its offset or address from Rb, the other from the immediate. All results are registered and appear one clock after the instruction is presented with its valid strobe. The consumer handles fetch redirection and delay-slot sequencing.

Top module: `bdu_branch_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero.
- R2: Results are registered: `res_valid_o` equals `valid_i` of the previous cycle. When `valid_i` was low, or the opcode (instr[31:26]) is not one of the four branch opcodes, all other outputs are zero.
- R3: Opcode 100110 (Rb form) and 101110 (immediate form) are unconditional branches and are always taken. Their modifiers are instr[20] for the delay slot, instr[19] for an absolute target and instr[18] for link.
- R4: For a relative target the result is pc + Rb (Rb form) or pc + imm (immediate form). For an absolute target it is Rb or imm.
- R5: `link_en_o` is high exactly for an unconditional branch with the link bit set. `link_val_o` is then the address of the branch instruction itself, and zero otherwise.
- R6: `bip_set_o` is high for an unconditional branch that links and is absolute without delay, and for any immediate-form unconditional branch that links.
- R7: Opcode 100111 (Rb offset) and 101111 (immediate offset) are conditional branches with the condition in instr[23:21]: 000 Ra==0, 001 Ra!=0, 010 Ra<0, 011 Ra<=0, 100 Ra>0, 101 Ra>=0, all signed. The target is always relative. instr[24] has no effect.
- R8: Condition codes 110 and 111 are never taken and raise `illegal_o`.
- R9: `delay_slot_o` is instr[20] for unconditional branches. For conditional branches it is instr[25], and only when the branch is taken.
- R10: When no branch is taken, `target_o` is zero.
- R11: Conditional branches never raise `link_en_o` or `bip_set_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the presented instruction |
| ra_i | input | 32 | Value of source register Ra |
| rb_i | input | 32 | Value of source register Rb |
| imm_i | input | 32 | Sign-extended immediate |
| res_valid_o | output | 1 | A result for last cycle's instruction is present |
| taken_o | output | 1 | Branch is taken |
| target_o | output | 32 | Branch target address |
| link_en_o | output | 1 | Request to write the link value to Rd |
| link_val_o | output | 32 | Value to write to Rd |
| delay_slot_o | output | 1 | The next instruction executes as a delay slot |
| bip_set_o | output | 1 | Set the break-in-progress status bit |
| illegal_o | output | 1 | Reserved condition code seen |

## Verification
Each result is due exactly one clock after the instruction is sampled. The one output register is the only stage between the inputs and the outputs. The bench drives each instruction on a falling edge, lets one rising edge capture it, and reads every output on the next falling edge. This keeps each check half a period clear of the edge that produced the value. Between vectors, valid is dropped for a full cycle, so a stale result cannot pass as a fresh one.

// File: rtl/bdu_pkg.sv
package bdu_pkg;

    localparam int OPC_W  = 6;
    localparam int COND_W = 3;

    localparam logic [OPC_W-1:0] OPC_UNC_REG = 6'b100110;
    localparam logic [OPC_W-1:0] OPC_UNC_IMM = 6'b101110;
    localparam logic [OPC_W-1:0] OPC_CND_REG = 6'b100111;
    localparam logic [OPC_W-1:0] OPC_CND_IMM = 6'b101111;

    typedef enum logic [1:0] {
        BK_NONE   = 2'd0,
        BK_UNCOND = 2'd1,
        BK_COND   = 2'd2
    } br_kind_e;

    typedef enum logic [COND_W-1:0] {
        CC_EQ  = 3'b000,
        CC_NE  = 3'b001,
        CC_LT  = 3'b010,
        CC_LE  = 3'b011,
        CC_GT  = 3'b100,
        CC_GE  = 3'b101,
        CC_RS6 = 3'b110,
        CC_RS7 = 3'b111
    } cond_e;

    typedef struct packed {
        br_kind_e kind;
        logic     use_imm;
        logic     dly;
        logic     absol;
        logic     link;
        cond_e    cond;
    } br_dec_t;

endpackage

// File: rtl/bdu_cond.sv
module bdu_cond
    import bdu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] ra_i,
    input  cond_e           cond_i,
    output logic            hit_o,
    output logic            legal_o
);

    logic is_zero;
    logic is_neg;

    assign is_zero = (ra_i == '0);
    assign is_neg  = ra_i[XLEN-1];

    always_comb begin
        hit_o   = 1'b0;
        legal_o = 1'b1;
        unique case (cond_i)
            CC_EQ:   hit_o = is_zero;
            CC_NE:   hit_o = !is_zero;
            CC_LT:   hit_o = is_neg;
            CC_LE:   hit_o = is_neg || is_zero;
            CC_GT:   hit_o = !is_neg && !is_zero;
            CC_GE:   hit_o = !is_neg;
            default: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bdu_target.sv
module bdu_target #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] rb_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic            use_imm_i,
    input  logic            absol_i,
    output logic [XLEN-1:0] target_o
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;

    assign base     = absol_i ? '0 : pc_i;
    assign offs     = use_imm_i ? imm_i : rb_i;
    assign target_o = base + offs;

endmodule

// File: rtl/bdu_decode.sv
module bdu_decode
    import bdu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] instr_i,
    output br_dec_t         dec_o
);

    // Field positions counted from the MSB (bit 0 is the MSB of the word).
    localparam int MSB     = XLEN - 1;
    localparam int P_C_DLY = MSB - 6;
    localparam int P_C_CHI = MSB - 8;
    localparam int P_U_DLY = MSB - 11;
    localparam int P_U_ABS = MSB - 12;
    localparam int P_U_LNK = MSB - 13;

    logic [OPC_W-1:0] opc;
    logic             unused_low;

    assign opc        = instr_i[MSB -: OPC_W];
    assign unused_low = ^{instr_i[P_C_DLY-1], instr_i[P_U_LNK-1:0]};

    always_comb begin
        dec_o         = '0;
        dec_o.kind    = BK_NONE;
        dec_o.cond    = CC_EQ;
        unique case (opc)
            OPC_UNC_REG, OPC_UNC_IMM: begin
                dec_o.kind    = BK_UNCOND;
                dec_o.use_imm = (opc == OPC_UNC_IMM);
                dec_o.dly     = instr_i[P_U_DLY];
                dec_o.absol   = instr_i[P_U_ABS];
                dec_o.link    = instr_i[P_U_LNK];
            end
            OPC_CND_REG, OPC_CND_IMM: begin
                dec_o.kind    = BK_COND;
                dec_o.use_imm = (opc == OPC_CND_IMM);
                dec_o.dly     = instr_i[P_C_DLY];
                dec_o.cond    = cond_e'(instr_i[P_C_CHI -: COND_W]);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bdu_branch_unit.sv
module bdu_branch_unit
    import bdu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            valid_i,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] ra_i,
    input  logic [XLEN-1:0] rb_i,
    input  logic [XLEN-1:0] imm_i,
    output logic            res_valid_o,
    output logic            taken_o,
    output logic [XLEN-1:0] target_o,
    output logic            link_en_o,
    output logic [XLEN-1:0] link_val_o,
    output logic            delay_slot_o,
    output logic            bip_set_o,
    output logic            illegal_o
);

    typedef struct packed {
        logic            vld;
        logic            taken;
        logic [XLEN-1:0] tgt;
        logic            lnk;
        logic [XLEN-1:0] lval;
        logic            dly;
        logic            bip;
        logic            ill;
    } res_t;

    br_dec_t         dec;
    logic            cond_hit;
    logic            cond_legal;
    logic [XLEN-1:0] tgt_w;
    res_t            res_d;
    res_t            res_q;

    bdu_decode #(.XLEN(XLEN)) i_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    bdu_cond #(.XLEN(XLEN)) i_cond (
        .ra_i    (ra_i),
        .cond_i  (dec.cond),
        .hit_o   (cond_hit),
        .legal_o (cond_legal)
    );

    bdu_target #(.XLEN(XLEN)) i_target (
        .pc_i      (pc_i),
        .rb_i      (rb_i),
        .imm_i     (imm_i),
        .use_imm_i (dec.use_imm),
        .absol_i   (dec.absol && (dec.kind == BK_UNCOND)),
        .target_o  (tgt_w)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = valid_i;
        if (valid_i) begin
            unique case (dec.kind)
                BK_UNCOND: begin
                    res_d.taken = 1'b1;
                    res_d.tgt   = tgt_w;
                    res_d.dly   = dec.dly;
                    res_d.lnk   = dec.link;
                    res_d.lval  = dec.link ? pc_i : '0;
                    res_d.bip   = dec.link &&
                                  ((dec.absol && !dec.dly) || dec.use_imm);
                end
                BK_COND: begin
                    if (!cond_legal) begin
                        res_d.ill = 1'b1;
                    end else if (cond_hit) begin
                        res_d.taken = 1'b1;
                        res_d.tgt   = tgt_w;
                        res_d.dly   = dec.dly;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid_o  = res_q.vld;
    assign taken_o      = res_q.taken;
    assign target_o     = res_q.tgt;
    assign link_en_o    = res_q.lnk;
    assign link_val_o   = res_q.lval;
    assign delay_slot_o = res_q.dly;
    assign bip_set_o    = res_q.bip;
    assign illegal_o    = res_q.ill;

endmodule

// File: rtl/bdu_branch_unit_chk.sv
module bdu_branch_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            valid_i,
    input logic [XLEN-1:0] pc_i,
    input logic            res_valid_o,
    input logic            taken_o,
    input logic [XLEN-1:0] target_o,
    input logic            link_en_o,
    input logic [XLEN-1:0] link_val_o,
    input logic            delay_slot_o,
    input logic            bip_set_o,
    input logic            illegal_o
);

    a_r2_result_follows_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> $past(valid_i));

    a_r2_nothing_without_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !res_valid_o |-> !taken_o && !link_en_o && !illegal_o);

    a_r5_link_is_branch_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_en_o |-> taken_o && (link_val_o == $past(pc_i)));

    a_r6_bip_needs_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bip_set_o |-> link_en_o);

    a_r8_illegal_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> !taken_o && !delay_slot_o);

    a_r9_delay_needs_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        delay_slot_o |-> taken_o);

    a_r10_untaken_target_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !taken_o |-> (target_o == '0) && !link_en_o && !bip_set_o);

endmodule

bind bdu_branch_unit bdu_branch_unit_chk #(.XLEN(XLEN)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .pc_i         (pc_i),
    .res_valid_o  (res_valid_o),
    .taken_o      (taken_o),
    .target_o     (target_o),
    .link_en_o    (link_en_o),
    .link_val_o   (link_val_o),
    .delay_slot_o (delay_slot_o),
    .bip_set_o    (bip_set_o),
    .illegal_o    (illegal_o)
);

// File: tb/test_bdu_branch_unit.sv
module test_bdu_branch_unit;

    localparam logic [31:0] PC0 = 32'h0000_1000;
    localparam logic [31:0] RB0 = 32'h0000_0040;
    localparam logic [31:0] IM0 = 32'hFFFF_FFF0;

    // Unconditional: opcode 10x110, instr[20] delay, [19] absolute, [18] link
    function automatic logic [31:0] enc_u(input logic f_imm, input logic d,
                                          input logic a, input logic l);
        return {2'b10, f_imm, 3'b110, 5'd15, d, a, l, 2'b00, 16'h0000};
    endfunction

    // Conditional: opcode 10x111, instr[25] delay, instr[23:21] condition
    function automatic logic [31:0] enc_c(input logic f_imm, input logic d,
                                          input logic [2:0] cc);
        return {2'b10, f_imm, 3'b111, d, 1'b0, cc, 5'd3, 16'h0000};
    endfunction

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] ra;
        logic        tk;
        logic [31:0] tgt;
        logic        lk;
        logic        dl;
        logic        bp;
        logic        il;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{enc_u(0,0,0,0), 32'h0,          1'b1, 32'h0000_1040, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{enc_u(0,1,1,0), 32'h0,          1'b1, 32'h0000_0040, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},  // R9
        '{enc_u(0,1,1,1), 32'h0,          1'b1, 32'h0000_0040, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
        '{enc_u(0,0,1,1), 32'h0,          1'b1, 32'h0000_0040, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
        '{enc_u(1,0,0,0), 32'h0,          1'b1, 32'h0000_0FF0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{enc_u(1,1,0,1), 32'h0,          1'b1, 32'h0000_0FF0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
        '{enc_u(1,0,1,0), 32'h0,          1'b1, 32'hFFFF_FFF0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{enc_c(0,0,3'b000), 32'h0,       1'b1, 32'h0000_1040, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{enc_c(0,0,3'b001), 32'h0,       1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
        '{enc_c(1,1,3'b010), 32'hFFFF_FFFF, 1'b1, 32'h0000_0FF0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9}, // R9
        '{enc_c(0,0,3'b011), 32'h0,       1'b1, 32'h0000_1040, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{enc_c(0,1,3'b100), 32'h0,       1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{enc_c(1,0,3'b101), 32'h8000_0000, 1'b0, 32'h0,       1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{enc_c(1,0,3'b100), 32'h5,       1'b1, 32'h0000_0FF0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{enc_c(0,0,3'b011), 32'h5,       1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{enc_c(0,0,3'b110), 32'h0,       1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
        '{enc_c(1,1,3'b111), 32'h0,       1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
        '{32'h0000_0000, 32'h0,           1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{enc_c(0,0,3'b010), 32'h0,       1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{enc_c(0,0,3'b000) | 32'h0100_0000, 32'h0, 1'b1, 32'h0000_1040, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7}, // R7
        '{enc_c(0,0,3'b101), 32'h7FFF_FFFF, 1'b1, 32'h0000_1040, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7}, // R7
        '{enc_c(1,1,3'b001), 32'h3,       1'b1, 32'h0000_0FF0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic [31:0] ra = '0;
    logic [31:0] rb = '0;
    logic [31:0] imm = '0;
    logic        res_valid;
    logic        taken;
    logic [31:0] target;
    logic        link_en;
    logic [31:0] link_val;
    logic        delay_slot;
    logic        bip_set;
    logic        illegal;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bdu_branch_unit i_bdu_branch_unit (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .valid_i      (valid),
        .instr_i      (instr),
        .pc_i         (pc),
        .ra_i         (ra),
        .rb_i         (rb),
        .imm_i        (imm),
        .res_valid_o  (res_valid),
        .taken_o      (taken),
        .target_o     (target),
        .link_en_o    (link_en),
        .link_val_o   (link_val),
        .delay_slot_o (delay_slot),
        .bip_set_o    (bip_set),
        .illegal_o    (illegal)
    );

    task automatic chk(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input int req, input logic rv, input logic tk,
                           input logic [31:0] tg, input logic lk, input logic [31:0] lv,
                           input logic dl, input logic bp, input logic il);
        chk("res_valid", req, {31'b0, res_valid}, {31'b0, rv});
        chk("taken",     req, {31'b0, taken},     {31'b0, tk});
        chk("target",    req, target,             tg);
        chk("link_en",   req, {31'b0, link_en},   {31'b0, lk});
        chk("link_val",  req, link_val,           lv);
        chk("delay",     req, {31'b0, delay_slot}, {31'b0, dl});
        chk("bip_set",   req, {31'b0, bip_set},   {31'b0, bp});
        chk("illegal",   req, {31'b0, illegal},   {31'b0, il});
    endtask

    task automatic present(input logic v, input logic [31:0] ins, input logic [31:0] a);
        @(negedge clk);
        valid = v;
        instr = ins;
        pc    = PC0;
        ra    = a;
        rb    = RB0;
        imm   = IM0;
        @(negedge clk);
        valid = 1'b0;
    endtask

    initial begin
        // R1: outputs zero during reset
        repeat (3) @(negedge clk);
        valid = 1'b1;
        instr = enc_u(0, 0, 0, 1);
        pc    = PC0;
        rb    = RB0;
        @(negedge clk);
        chk_all(1, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all(1, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            present(1'b1, VECS[i].instr, VECS[i].ra);
            chk_all(int'(VECS[i].req), 1'b1, VECS[i].tk, VECS[i].tgt, VECS[i].lk,
                    VECS[i].lk ? PC0 : 32'h0, VECS[i].dl, VECS[i].bp, VECS[i].il);
        end

        // R2: a branch presented without valid produces no result
        present(1'b0, enc_u(0, 1, 1, 1), 32'h0);
        chk_all(2, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

        // R2: result drops one cycle after the valid pulse
        @(negedge clk);
        chk("res_valid idle", 2, {31'b0, res_valid}, 32'h0);

        // R6: absolute link with delay does not set break flag (register form)
        present(1'b1, enc_u(0, 1, 1, 1), 32'h0);
        chk("bip abs+link+delay", 6, {31'b0, bip_set}, 32'h0);

        // R1: reset in mid-stream clears a held result
        @(negedge clk);
        valid = 1'b1;
        instr = enc_u(1, 1, 0, 1);
        @(negedge clk);
        chk("taken before reset", 3, {31'b0, taken}, 32'h1);
        rst_n = 1'b0;
        #1;
        chk_all(1, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL R2 watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule